// File: doc/BRIEF.md
# Batch-Capped Thread-Ranked Request Picker

This block decides which pending memory request a controller sends next. It looks at a request queue that lives outside it, one entry per slot with a valid flag, an issuing thread, a target bank, a target row and an age. It also looks at the row currently held open in each bank. Each cycle it registers the index of the winning entry.

Fairness comes from batching. When no batched request is left in the queue, the block marks a new batch. Within each (thread, bank) pair, only the oldest few requests are marked, up to a cap. While a batch is live, marked entries win over unmarked ones. Below that, the order is: an open-row hit, then the better thread rank, then the greater age. Ranks are set each time a batch forms. A thread with a lighter load in the batch gets a better rank, so a light thread is not stuck behind a heavy one. Command timing is left to the logic downstream.

Top module: `pbs_sched`

## Requirements
- R1: After reset, `pick_valid_o` is 0 and no entry is marked. Thread ranks start equal to the thread ID, and a lower value is a better rank.
- R2: `pick_valid_o`/`pick_idx_o` are registered. They show the choice made from the inputs one cycle earlier. When no entry is valid, `pick_valid_o` is 0 in the next cycle. A pick always names an entry that was valid.
- R3: A batch forms only in a cycle in which no valid entry is marked and at least one entry is valid. Its marks and ranks take effect from the next cycle. Entries that arrive while a batch is live stay unmarked.
- R4: At formation, at most CAP entries are marked per (thread, bank) pair, and they are the oldest ones. A larger age is older. On equal age, the lower index is older.
- R5: If any valid entry is marked, the pick is a marked entry.
- R6: Among entries with the same mark state, a row hit wins. A hit means `bank_open_i[bank]` is 1 and `open_row_i[bank]` equals the entry's row.
- R7: At formation, ranks are assigned as follows. A lower maximum marked count over banks ranks better. Ties go to the lower total marked count, then to the lower thread ID. Ranks hold until the next formation. Next in priority after R6, the better-ranked thread wins.
- R8: After R5 to R7, the larger age wins. Full ties go to the lower index.
- R9: The mark of an entry clears in the cycle after its valid input is 0. A queue must hold valid low for at least one cycle before it reuses a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| req_valid_i | input | N | entry occupied |
| req_thread_i | input | N*TW | thread of each entry |
| req_bank_i | input | N*BW | bank of each entry |
| req_row_i | input | N*RW | row of each entry |
| req_age_i | input | N*AW | saturating age of each entry |
| bank_open_i | input | B | bank holds an open row |
| open_row_i | input | B*RW | open row per bank |
| pick_valid_o | output | 1 | a pick was made |
| pick_idx_o | output | IW | chosen entry index |

## Verification
The hardest case to reach is a live batch sitting next to a newer, unmarked entry that would otherwise win. That entry may be a row hit, older, or from a better-ranked thread. A queue that fills and drains at random seldom stops on this mix. Directed steps therefore build a thread with more than CAP requests to one bank. They then make the left-out entry a row hit while the batch is still live, and later let the batch drain so the next one forms. A long random run then retires each picked entry and refills free slots. It uses few rows, so hits are common, and saturating ages, so equal-age ties occur often.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
    localparam int PBS_ENTRIES = 8;
    localparam int PBS_THREADS = 4;
    localparam int PBS_BANKS   = 4;
    localparam int PBS_ROW_W   = 8;
    localparam int PBS_AGE_W   = 4;
    localparam int PBS_CAP     = 2;

    // true when slot a is older than slot b (age first, then lower index)
    function automatic logic is_older(int age_a, int idx_a, int age_b, int idx_b);
        return (age_a > age_b) || ((age_a == age_b) && (idx_a < idx_b));
    endfunction
endpackage

// File: rtl/pbs_batch.sv
module pbs_batch #(
    parameter  int N   = pbs_pkg::PBS_ENTRIES,
    parameter  int T   = pbs_pkg::PBS_THREADS,
    parameter  int B   = pbs_pkg::PBS_BANKS,
    parameter  int AW  = pbs_pkg::PBS_AGE_W,
    parameter  int CAP = pbs_pkg::PBS_CAP,
    localparam int TW  = (T > 1) ? $clog2(T) : 1,
    localparam int BW  = (B > 1) ? $clog2(B) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N-1:0]           valid_i,
    input  logic [N-1:0][TW-1:0]   thread_i,
    input  logic [N-1:0][BW-1:0]   bank_i,
    input  logic [N-1:0][AW-1:0]   age_i,
    output logic [N-1:0]           mark_o,
    output logic [T-1:0][TW-1:0]   rank_o
);
    localparam int CW = $clog2(N + 1);

    typedef struct packed {
        logic [N-1:0]         mark;
        logic [T-1:0][TW-1:0] rank;
    } batch_t;

    batch_t st_d, st_q;
    logic   none_live, form;
    logic [N-1:0]          fresh;
    logic [CW-1:0]         ahead   [N];
    logic [CW-1:0]         per_tb  [T][B];
    logic [CW-1:0]         peak    [T];
    logic [CW-1:0]         total   [T];
    logic [T-1:0][TW-1:0]  new_rank;

    always_comb begin
        none_live = ~|(st_q.mark & valid_i);
        form      = none_live & (|valid_i);
        // mark the CAP oldest of each (thread, bank) group
        for (int i = 0; i < N; i++) begin
            ahead[i] = '0;
            for (int j = 0; j < N; j++) begin
                if (j != i && valid_i[j] && thread_i[j] == thread_i[i] &&
                    bank_i[j] == bank_i[i] &&
                    pbs_pkg::is_older(int'(age_i[j]), j, int'(age_i[i]), i))
                    ahead[i] = ahead[i] + CW'(1);
            end
            fresh[i] = valid_i[i] && (ahead[i] < CW'(CAP));
        end
        // per-thread load in the batch being formed
        for (int t = 0; t < T; t++) begin
            peak[t]  = '0;
            total[t] = '0;
            for (int b = 0; b < B; b++) begin
                per_tb[t][b] = '0;
                for (int i = 0; i < N; i++)
                    if (fresh[i] && thread_i[i] == TW'(t) && bank_i[i] == BW'(b))
                        per_tb[t][b] = per_tb[t][b] + CW'(1);
                if (per_tb[t][b] > peak[t]) peak[t] = per_tb[t][b];
                total[t] = total[t] + per_tb[t][b];
            end
        end
        // rank = number of threads that are lighter (0 is best)
        for (int t = 0; t < T; t++) begin
            new_rank[t] = '0;
            for (int u = 0; u < T; u++) begin
                if (u != t && ((peak[u] < peak[t]) ||
                               (peak[u] == peak[t] && total[u] < total[t]) ||
                               (peak[u] == peak[t] && total[u] == total[t] && u < t)))
                    new_rank[t] = new_rank[t] + TW'(1);
            end
        end
        st_d.mark = form ? fresh : (st_q.mark & valid_i);
        st_d.rank = form ? new_rank : st_q.rank;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mark <= '0;
            for (int t = 0; t < T; t++) st_q.rank[t] <= TW'(t);
        end else begin
            st_q <= st_d;
        end
    end

    assign mark_o = st_q.mark;
    assign rank_o = st_q.rank;

    // held marks per (thread, bank), counted from state for the cap check
    logic [CW-1:0] held [T][B];
    always_comb begin
        for (int t = 0; t < T; t++)
            for (int b = 0; b < B; b++) begin
                held[t][b] = '0;
                for (int i = 0; i < N; i++)
                    if (st_q.mark[i] && valid_i[i] && thread_i[i] == TW'(t) && bank_i[i] == BW'(b))
                        held[t][b] = held[t][b] + CW'(1);
            end
    end

    for (genvar gt = 0; gt < T; gt++) begin : g_cap_t
        for (genvar gb = 0; gb < B; gb++) begin : g_cap_b
            a_r4_cap: assert property (@(posedge clk) disable iff (!rst_n)
                held[gt][gb] <= CW'(CAP));
        end
    end

    for (genvar gi = 0; gi < N; gi++) begin : g_mark_chk
        a_r3_form_when_drained: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.mark[gi] && !$past(st_q.mark[gi])) |-> $past(none_live));
        a_r9_clear_on_free: assert property (@(posedge clk) disable iff (!rst_n)
            !valid_i[gi] |=> !st_q.mark[gi]);
    end
endmodule

// File: rtl/pbs_pick.sv
module pbs_pick #(
    parameter  int N  = pbs_pkg::PBS_ENTRIES,
    parameter  int T  = pbs_pkg::PBS_THREADS,
    parameter  int B  = pbs_pkg::PBS_BANKS,
    parameter  int RW = pbs_pkg::PBS_ROW_W,
    parameter  int AW = pbs_pkg::PBS_AGE_W,
    localparam int TW = (T > 1) ? $clog2(T) : 1,
    localparam int BW = (B > 1) ? $clog2(B) : 1,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]          valid_i,
    input  logic [N-1:0][TW-1:0]  thread_i,
    input  logic [N-1:0][BW-1:0]  bank_i,
    input  logic [N-1:0][RW-1:0]  row_i,
    input  logic [N-1:0][AW-1:0]  age_i,
    input  logic [N-1:0]          mark_i,
    input  logic [T-1:0][TW-1:0]  rank_i,
    input  logic [B-1:0]          bank_open_i,
    input  logic [B-1:0][RW-1:0]  open_row_i,
    output logic                  found_o,
    output logic [IW-1:0]         idx_o
);
    localparam int KW = 2 + TW + AW;

    logic [N-1:0][KW-1:0] key;
    logic [N-1:0]         hit;

    // key order: batch mark, row hit, inverted rank, age
    for (genvar gi = 0; gi < N; gi++) begin : g_key
        assign hit[gi] = bank_open_i[bank_i[gi]] && (open_row_i[bank_i[gi]] == row_i[gi]);
        assign key[gi] = {mark_i[gi], hit[gi], ~rank_i[thread_i[gi]], age_i[gi]};
    end

    // strict compare in ascending index keeps the lower index on ties
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = 0; i < N; i++) begin
            if (valid_i[i] && (!found_o || key[i] > key[idx_o])) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pbs_sched.sv
module pbs_sched #(
    parameter  int N   = pbs_pkg::PBS_ENTRIES,
    parameter  int T   = pbs_pkg::PBS_THREADS,
    parameter  int B   = pbs_pkg::PBS_BANKS,
    parameter  int RW  = pbs_pkg::PBS_ROW_W,
    parameter  int AW  = pbs_pkg::PBS_AGE_W,
    parameter  int CAP = pbs_pkg::PBS_CAP,
    localparam int TW  = (T > 1) ? $clog2(T) : 1,
    localparam int BW  = (B > 1) ? $clog2(B) : 1,
    localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          req_valid_i,
    input  logic [N-1:0][TW-1:0]  req_thread_i,
    input  logic [N-1:0][BW-1:0]  req_bank_i,
    input  logic [N-1:0][RW-1:0]  req_row_i,
    input  logic [N-1:0][AW-1:0]  req_age_i,
    input  logic [B-1:0]          bank_open_i,
    input  logic [B-1:0][RW-1:0]  open_row_i,
    output logic                  pick_valid_o,
    output logic [IW-1:0]         pick_idx_o
);
    typedef struct packed {
        logic          v;
        logic [IW-1:0] idx;
    } sel_t;

    sel_t                 sel_d, sel_q;
    logic [N-1:0]         mark;
    logic [T-1:0][TW-1:0] rank;
    logic                 found;
    logic [IW-1:0]        idx;

    pbs_batch #(.N(N), .T(T), .B(B), .AW(AW), .CAP(CAP)) batch_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (req_valid_i),
        .thread_i (req_thread_i),
        .bank_i   (req_bank_i),
        .age_i    (req_age_i),
        .mark_o   (mark),
        .rank_o   (rank)
    );

    pbs_pick #(.N(N), .T(T), .B(B), .RW(RW), .AW(AW)) pick_i (
        .valid_i     (req_valid_i),
        .thread_i    (req_thread_i),
        .bank_i      (req_bank_i),
        .row_i       (req_row_i),
        .age_i       (req_age_i),
        .mark_i      (mark),
        .rank_i      (rank),
        .bank_open_i (bank_open_i),
        .open_row_i  (open_row_i),
        .found_o     (found),
        .idx_o       (idx)
    );

    always_comb begin
        sel_d.v   = found;
        sel_d.idx = found ? idx : sel_q.idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    assign pick_valid_o = sel_q.v;
    assign pick_idx_o   = sel_q.idx;

    a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(|req_valid_i) |=> !pick_valid_o);
    a_r2_names_valid: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> req_valid_i[idx]);
    a_r5_batch_first: assert property (@(posedge clk) disable iff (!rst_n)
        (found && |(mark & req_valid_i)) |-> mark[idx]);
endmodule

// File: tb/pbs_sched_tb_top.sv
`timescale 1ns/1ps
module pbs_sched_tb_top;
    localparam int N = 8, T = 4, B = 4, RW = 8, AW = 4, CAP = 2;
    localparam int TW = 2, BW = 2, IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [N-1:0]          v;
    logic [N-1:0][TW-1:0]  th;
    logic [N-1:0][BW-1:0]  bk;
    logic [N-1:0][RW-1:0]  rw;
    logic [N-1:0][AW-1:0]  ag;
    logic [B-1:0]          bo;
    logic [B-1:0][RW-1:0]  orow;
    logic                  pv;
    logic [IW-1:0]         pi;

    pbs_sched #(.N(N), .T(T), .B(B), .RW(RW), .AW(AW), .CAP(CAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid_i(v), .req_thread_i(th), .req_bank_i(bk),
        .req_row_i(rw), .req_age_i(ag), .bank_open_i(bo), .open_row_i(orow),
        .pick_valid_o(pv), .pick_idx_o(pi));

    int n_run = 0, n_fail = 0;
    bit done = 0;
    bit mmark [N];
    int mrank [T];
    int exp_idx;

    task automatic chk(bit ok, string tag, int act, int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic bit m_hit(int i);
        return bo[bk[i]] && (orow[bk[i]] == rw[i]);
    endfunction

    function automatic bit m_better(int i, int b);
        if (mmark[i] != mmark[b]) return mmark[i];
        if (m_hit(i) != m_hit(b)) return m_hit(i);
        if (mrank[th[i]] != mrank[th[b]]) return mrank[th[i]] < mrank[th[b]];
        return ag[i] > ag[b];
    endfunction

    function automatic int m_pick();
        int best = -1;
        for (int i = 0; i < N; i++)
            if (v[i] && (best < 0 || m_better(i, best))) best = i;
        return best;
    endfunction

    task automatic m_update();
        bit live = 0, any = 0;
        for (int i = 0; i < N; i++) begin
            live |= mmark[i] & v[i];
            any  |= v[i];
        end
        if (!live && any) begin
            int cnt [T][B];
            int pk [T], tot [T];
            for (int t = 0; t < T; t++) begin
                pk[t] = 0; tot[t] = 0;
                for (int b = 0; b < B; b++) cnt[t][b] = 0;
            end
            for (int i = 0; i < N; i++) begin
                int older = 0;
                for (int j = 0; j < N; j++)
                    if (v[j] && j != i && th[j] == th[i] && bk[j] == bk[i] &&
                        (ag[j] > ag[i] || (ag[j] == ag[i] && j < i))) older++;
                mmark[i] = v[i] && older < CAP;
                if (mmark[i]) cnt[th[i]][bk[i]]++;
            end
            for (int t = 0; t < T; t++)
                for (int b = 0; b < B; b++) begin
                    tot[t] += cnt[t][b];
                    if (cnt[t][b] > pk[t]) pk[t] = cnt[t][b];
                end
            for (int t = 0; t < T; t++) begin
                mrank[t] = 0;
                for (int u = 0; u < T; u++)
                    if (pk[u] < pk[t] || (pk[u] == pk[t] && (tot[u] < tot[t] ||
                        (tot[u] == tot[t] && u < t)))) mrank[t]++;
            end
        end else begin
            for (int i = 0; i < N; i++) mmark[i] = mmark[i] & v[i];
        end
    endtask

    // one clock: predict, let the edge pass, compare, advance the model
    task automatic step(string tag);
        exp_idx = m_pick();
        @(posedge clk); #1;
        chk(pv == (exp_idx >= 0), {tag, " valid"}, int'(pv), int'(exp_idx >= 0));
        if (exp_idx >= 0) chk(int'(pi) == exp_idx, {tag, " index"}, int'(pi), exp_idx);
        m_update();
        @(negedge clk);
    endtask

    task automatic put(int i, int t, int b, int r, int a);
        v[i] = 1'b1; th[i] = TW'(t); bk[i] = BW'(b); rw[i] = RW'(r); ag[i] = AW'(a);
    endtask

    initial begin
        bit freed [N];
        void'($urandom(32'd4242));
        v = '0; th = '0; bk = '0; rw = '0; ag = '0; bo = '0; orow = '0;
        for (int i = 0; i < N; i++) mmark[i] = 0;
        for (int t = 0; t < T; t++) mrank[t] = t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 chk(pv == 1'b0, "R1 reset pick_valid", int'(pv), 0);
        @(negedge clk);

        // directed: thread 0 has three requests to bank 0, cap is two
        put(0, 0, 0, 10, 3); put(1, 0, 0, 11, 7); put(2, 0, 0, 12, 7); put(3, 1, 1, 20, 1);
        step("R7/R8 reset ranks and age tie");
        chk(int'(pi) == 1, "R8 lower index on equal age", int'(pi), 1);
        step("R7 lighter thread first");
        chk(int'(pi) == 3, "R7 lighter thread wins", int'(pi), 3);
        v[3] = 1'b0; bo[0] = 1'b1; orow[0] = 8'd10;
        step("R4/R5 unmarked hit loses");
        chk(int'(pi) == 1, "R4 R5 excess entry left out", int'(pi), 1);
        orow[0] = 8'd12;
        step("R6 hit among marked");
        chk(int'(pi) == 2, "R6 row hit wins", int'(pi), 2);
        v[1] = 1'b0; v[2] = 1'b0;
        step("R9/R3 drain then new batch");
        chk(int'(pi) == 0, "R9 R3 lone entry", int'(pi), 0);
        put(4, 2, 0, 12, 9);
        step("R3 late arrival unmarked");
        chk(int'(pi) == 0, "R3 late hit stays outside batch", int'(pi), 0);
        v = '0;
        step("R2 one more");
        step("R2 empty queue");
        chk(pv == 1'b0, "R2 no pick when empty", int'(pv), 0);

        // random: retire picks, refill free slots, few rows, saturating ages
        for (int c = 0; c < 4000; c++) begin
            for (int i = 0; i < N; i++) freed[i] = 0;
            if (pv && ($urandom_range(0, 9) < 8) && v[pi]) begin
                v[pi] = 1'b0; freed[pi] = 1;
            end
            for (int i = 0; i < N; i++) begin
                if (v[i]) begin
                    if (ag[i] != '1 && $urandom_range(0, 1) == 1) ag[i] = ag[i] + AW'(1);
                end else if (!freed[i] && $urandom_range(0, 9) < 3) begin
                    put(i, $urandom_range(0, T-1), $urandom_range(0, B-1),
                        $urandom_range(0, 3), $urandom_range(0, 2));
                end
            end
            if ($urandom_range(0, 3) == 0) begin
                bo = B'($urandom_range(0, (1 << B) - 1));
                for (int b = 0; b < B; b++) orow[b] = RW'($urandom_range(0, 3));
            end
            step("R5/R6/R7/R8 random");
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule